// File: doc/BRIEF.md
# Multi-Standard Audio Serial Transceiver

This block is a full-duplex, clock-driving audio serial port. It generates the serial bit clock and the channel-select line from an enable pulse that arrives at twice the bit rate. One stereo pair is shifted out per frame and one pair is shifted in over the same frame. Parallel samples enter through a one-deep transmit holding register with a valid/ready handshake. Received pairs leave through a one-deep holding register with its own valid/ready handshake.

The framing is chosen at run time from four layouts. In the classic two-channel layout the MSB lags the select edge by one bit. In the MSB-aligned layout the MSB coincides with the select edge. In the LSB-aligned layout each sample is padded in front. In the pulse-synchronised layout a one-bit sync pulse comes before a back-to-back left/right pair. The slot length (16 or 32 bits) and the sample length (16, 24 or 32 bits) are set separately. The bit-clock polarity and the select polarity can each be inverted. An empty transmit holding register at a frame start and an unread receive register at a frame end each raise a sticky flag. All configuration inputs are static while the port is enabled.

Top module: `aud_serial_port`

## Requirements
- R1: While `enable` is low, `sck` rests at the `clk_inv` level, `ws` rests at the `ws_inv` level and `sd_out` is 0. The port leaves the idle state on the first `bclk_en` pulse after `enable` rises. It returns to idle one cycle after `enable` falls, even in the middle of a frame.
- R2: Each `bclk_en` pulse moves the internal bit clock by one half period, so one bit lasts two pulses. `sd_out` changes only on the launch edge, where the internal clock falls. `sd_in` is sampled on the opposite edge. A frame has 2×slot bits.
- R3: With `fmt_sel`=0, the select line is low for the left slot. It changes one bit before each slot, so the MSB of each sample follows the select edge by one bit.
- R4: With `fmt_sel`=1, the select line is low during the left slot and high during the right slot. The MSB of each sample is the first bit of its slot.
- R5: With `fmt_sel`=2, the select line is low during the left slot and high during the right slot. The sample LSB is the last bit of its slot, and the leading pad bits are 0.
- R6: With `fmt_sel`=3, the select line is high only during the last bit of the frame, just before the left MSB. Left and right samples follow each other with no gap, and the remaining bits of the frame are 0.
- R7: `slot_long`=0 gives 16-bit slots and `slot_long`=1 gives 32-bit slots.
- R8: `smp_len` selects 0=16, 1=24 or 2/3=32 sample bits, capped at the slot length. Samples sit in bits [n-1:0] of the 32-bit words, sent and received MSB first. Higher transmit bits are ignored.
- R9: `clk_inv`=1 inverts `sck`, so data launches on the rising pin edge and is sampled on the falling one. `ws_inv`=1 inverts `ws`.
- R10: After the last bit of a frame is sampled, the received pair is offered on `rx_valid` in the next cycle. Unused bits of the pair are 0. The pair is held stable until `rx_ready` is seen.
- R11: `tx_underrun` is set when a frame starts while the transmit holding register is empty. That frame sends zeros. The flag stays set until reset.
- R12: `rx_overrun` is set when a frame ends while the previous pair is still unread. The unread pair is kept and the new one is dropped. The flag stays set until reset.
- R13: `tx_ready` is low while the transmit holding register is full. Offers made while it is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port run enable |
| bclk_en | input | 1 | Half-bit-period strobe |
| fmt_sel | input | 2 | Framing layout: 0 classic, 1 MSB-aligned, 2 LSB-aligned, 3 pulse-sync |
| slot_long | input | 1 | Slot length: 0 = 16 bits, 1 = 32 bits |
| smp_len | input | 2 | Sample length: 0 = 16, 1 = 24, 2/3 = 32 bits |
| clk_inv | input | 1 | Invert bit clock |
| ws_inv | input | 1 | Invert select line |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_left | input | 32 | Left transmit sample |
| tx_right | input | 32 | Right transmit sample |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair taken |
| rx_left | output | 32 | Left received sample |
| rx_right | output | 32 | Right received sample |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select / frame sync |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The checker assumes that `fmt_sel`, `slot_long`, `smp_len`, `clk_inv` and `ws_inv` change only while `enable` is low or during reset. Its pin-edge properties also assume that `bclk_en` is the only cause of a bit-clock step while the port runs. The stimulus follows both rules: every configuration is applied under reset with the port disabled, and the strobe is a free-running pulse on every second cycle. With serial data looped back, the received pair must match the transmitted pair. This lets the serial layout and the receive path be checked against the same independently computed stream.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;
  localparam int SMP_W = 32;
  localparam int POS_W = $clog2(2 * SMP_W);
  localparam int IDX_W = $clog2(SMP_W);

  typedef enum logic [1:0] {
    FMT_CLASSIC = 2'd0,
    FMT_MSB_AL  = 2'd1,
    FMT_LSB_AL  = 2'd2,
    FMT_PULSE   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic             right;
    logic [IDX_W-1:0] idx;
  } slot_t;

  function automatic int slot_bits(input logic slot_long);
    return slot_long ? SMP_W : SMP_W / 2;
  endfunction

  function automatic int sample_bits(input logic [1:0] len, input logic slot_long);
    int n;
    case (len)
      2'd0:    n = 16;
      2'd1:    n = 24;
      default: n = 32;
    endcase
    if (n > slot_bits(slot_long)) n = slot_bits(slot_long);
    return n;
  endfunction

  // Which sample bit, if any, travels in frame position pos.
  function automatic slot_t slot_map(input logic [1:0] fmt, input logic slot_long,
                                     input logic [1:0] len, input logic [POS_W-1:0] pos);
    int    ch, n, q, k;
    slot_t s;
    ch = slot_bits(slot_long);
    n  = sample_bits(len, slot_long);
    q  = int'(pos);
    s  = '0;
    if (fmt_e'(fmt) == FMT_PULSE) begin
      if (q < n) begin
        s.hit = 1'b1; s.right = 1'b0; s.idx = IDX_W'(n - 1 - q);
      end else if (q < 2 * n) begin
        s.hit = 1'b1; s.right = 1'b1; s.idx = IDX_W'(2 * n - 1 - q);
      end
    end else begin
      s.right = (q >= ch);
      k = s.right ? q - ch : q;
      if (fmt_e'(fmt) == FMT_LSB_AL) begin
        s.hit = (k >= ch - n);
        s.idx = IDX_W'(ch - 1 - k);
      end else begin
        s.hit = (k < n);
        s.idx = IDX_W'(n - 1 - k);
      end
    end
    return s;
  endfunction

  // Un-inverted select level for frame position pos.
  function automatic logic ws_level(input logic [1:0] fmt, input logic slot_long,
                                    input logic [POS_W-1:0] pos);
    int ch, q;
    ch = slot_bits(slot_long);
    q  = int'(pos);
    case (fmt_e'(fmt))
      FMT_CLASSIC: return (q >= ch - 1) && (q < 2 * ch - 1);
      FMT_PULSE:   return q == 2 * ch - 1;
      default:     return q >= ch;
    endcase
  endfunction
endpackage

// File: rtl/aud_sp_clkgen.sv
module aud_sp_clkgen
  import aud_sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bclk_en,
  input  logic             slot_long,
  output logic             run,
  output logic             phase,
  output logic [POS_W-1:0] pos,
  output logic             frame_load,
  output logic             sample_evt,
  output logic             last_sample
);
  logic [POS_W-1:0] last_pos;
  logic             start_evt, wrap_evt;

  assign last_pos    = POS_W'(2 * slot_bits(slot_long) - 1);
  assign start_evt   = enable && !run && bclk_en;
  assign wrap_evt    = run && bclk_en && phase && (pos == last_pos);
  assign frame_load  = start_evt || wrap_evt;
  assign sample_evt  = run && bclk_en && !phase;
  assign last_sample = sample_evt && (pos == last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      run   <= 1'b0;
      phase <= 1'b0;
      pos   <= '0;
    end else if (!run) begin
      if (bclk_en) begin
        run   <= 1'b1;
        phase <= 1'b0;
        pos   <= '0;
      end
    end else if (bclk_en) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        pos   <= (pos == last_pos) ? '0 : pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_sp_tx.sv
module aud_sp_tx
  import aud_sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             frame_load,
  input  slot_t            slot,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [SMP_W-1:0] tx_left,
  input  logic [SMP_W-1:0] tx_right,
  output logic             sd_out,
  output logic             tx_underrun
);
  logic [SMP_W-1:0] hold_l, hold_r, cur_l, cur_r, word;
  logic             hold_full, accept;

  assign tx_ready = !hold_full;
  assign accept   = tx_valid && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l      <= '0;
      hold_r      <= '0;
      cur_l       <= '0;
      cur_r       <= '0;
      hold_full   <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      if (accept) begin
        hold_l <= tx_left;
        hold_r <= tx_right;
      end
      if (frame_load) begin
        if (hold_full) begin
          cur_l <= hold_l;
          cur_r <= hold_r;
        end else begin
          cur_l       <= '0;
          cur_r       <= '0;
          tx_underrun <= 1'b1;
        end
      end
      if (frame_load && hold_full) hold_full <= 1'b0;
      else if (accept)             hold_full <= 1'b1;
    end
  end

  always_comb begin
    word   = slot.right ? cur_r : cur_l;
    sd_out = run && slot.hit && word[slot.idx];
  end
endmodule

// File: rtl/aud_sp_rx.sv
module aud_sp_rx
  import aud_sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sample_evt,
  input  logic             last_sample,
  input  slot_t            slot,
  input  logic             sd_in,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [SMP_W-1:0] rx_left,
  output logic [SMP_W-1:0] rx_right,
  output logic             rx_overrun
);
  logic [SMP_W-1:0] acc_l, acc_r, acc_l_n, acc_r_n;

  always_comb begin
    acc_l_n = acc_l;
    acc_r_n = acc_r;
    if (sample_evt && slot.hit) begin
      if (slot.right) acc_r_n[slot.idx] = sd_in;
      else            acc_l_n[slot.idx] = sd_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_l      <= '0;
      acc_r      <= '0;
      rx_left    <= '0;
      rx_right   <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (!run || last_sample) begin
        acc_l <= '0;
        acc_r <= '0;
      end else begin
        acc_l <= acc_l_n;
        acc_r <= acc_r_n;
      end
      if (last_sample) begin
        if (rx_valid && !rx_ready) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_left  <= acc_l_n;
          rx_right <= acc_r_n;
          rx_valid <= 1'b1;
        end
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        bclk_en,
  input  logic [1:0]  fmt_sel,
  input  logic        slot_long,
  input  logic [1:0]  smp_len,
  input  logic        clk_inv,
  input  logic        ws_inv,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [31:0] tx_left,
  input  logic [31:0] tx_right,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [31:0] rx_left,
  output logic [31:0] rx_right,
  output logic        sck,
  output logic        ws,
  output logic        sd_out,
  input  logic        sd_in,
  output logic        tx_underrun,
  output logic        rx_overrun
);
  logic             run, phase, frame_load, sample_evt, last_sample;
  logic [POS_W-1:0] pos;
  slot_t            slot;

  aud_sp_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_en(bclk_en),
    .slot_long(slot_long), .run(run), .phase(phase), .pos(pos),
    .frame_load(frame_load), .sample_evt(sample_evt), .last_sample(last_sample)
  );

  assign slot = slot_map(fmt_sel, slot_long, smp_len, pos);
  assign sck  = phase ^ clk_inv;
  assign ws   = (run && ws_level(fmt_sel, slot_long, pos)) ^ ws_inv;

  aud_sp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .frame_load(frame_load), .slot(slot),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .sd_out(sd_out), .tx_underrun(tx_underrun)
  );

  aud_sp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_evt(sample_evt),
    .last_sample(last_sample), .slot(slot), .sd_in(sd_in),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left),
    .rx_right(rx_right), .rx_overrun(rx_overrun)
  );
endmodule

// File: rtl/aud_sp_checker.sv
module aud_sp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        bclk_en,
  input logic        clk_inv,
  input logic        ws_inv,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_left,
  input logic        sck,
  input logic        ws,
  input logic        sd_out,
  input logic        last_sample,
  input logic        tx_underrun,
  input logic        rx_overrun
);
  // R1: disabled port rests at idle levels
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sck == clk_inv) && (ws == ws_inv) && !sd_out);

  // R2: bit clock steps only on a strobe, or when stopping
  a_r2_sck_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) && (clk_inv == $past(clk_inv)) |-> $past(bclk_en) || !$past(enable));

  // R2: data moves only with the clock at its launch level
  a_r2_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $past(enable) && (sd_out != $past(sd_out)) |-> (sck == clk_inv));

  // R10: last sampled bit produces an offered pair
  a_r10_pair_offered: assert property (@(posedge clk) disable iff (!rst_n)
    last_sample |=> rx_valid);

  // R10: offered pair held until taken
  a_r10_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_left));

  // R11: underrun is sticky
  a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_underrun) |-> tx_underrun);

  // R12: overrun is sticky and only rises with an unread pair
  a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_overrun) |-> rx_overrun);
  a_r12_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid);

  // R13: a taken offer fills the holding register
  a_r13_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
endmodule

bind aud_serial_port aud_sp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_en(bclk_en),
  .clk_inv(clk_inv), .ws_inv(ws_inv), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .sck(sck),
  .ws(ws), .sd_out(sd_out), .last_sample(last_sample),
  .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bclk_en = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        slot_long = 1'b0;
  logic [1:0]  smp_len = 2'd0;
  logic        clk_inv = 1'b0;
  logic        ws_inv = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [31:0] rx_left, rx_right;
  logic        sck, ws, sd_out, sd_in;
  logic        tx_underrun, rx_overrun;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) bclk_en <= ~bclk_en;
  assign sd_in = sd_out;

  aud_serial_port dut_i (.*);

  // Monitor: pin-level capture on each sampling edge, and taken rx pairs
  int          cyc = 0;
  int          rise_cnt = 0;
  int          rx_cnt = 0;
  logic        prev_sck = 1'b0;
  logic        cap_sd [512];
  logic        cap_ws [512];
  int          cap_t  [512];
  logic [31:0] got_l, got_r;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (sck != prev_sck && (sck ^ clk_inv)) begin
      cap_sd[rise_cnt % 512] = sd_out;
      cap_ws[rise_cnt % 512] = ws ^ ws_inv;
      cap_t[rise_cnt % 512]  = cyc;
      rise_cnt = rise_cnt + 1;
    end
    prev_sck = sck;
    if (rx_valid && rx_ready) begin
      got_l  = rx_left;
      got_r  = rx_right;
      rx_cnt = rx_cnt + 1;
    end
  end

  // {fmt[70:69], slot_long[68], len[67:66], clk_inv[65], ws_inv[64], left, right}
  localparam int NV = 8;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 32'hA5C3_0F81, 32'h1234_5679},
    {2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 32'hFFAB_CDEF, 32'h0012_3457},
    {2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0000_BEEF, 32'hFFFF_1357},
    {2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0000_C001, 32'h0000_8E71},
    {2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h0000_7FFE, 32'h0000_0001},
    {2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 32'h00F0_0F0F, 32'h0055_AA33},
    {2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {2'd2, 1'b1, 2'd1, 1'b1, 1'b1, 32'h0080_0001, 32'h007F_FFFE}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] len, input logic sl);
    int n;
    n = (len == 2'd0) ? 16 : (len == 2'd1) ? 24 : 32;
    return (n > (sl ? 32 : 16)) ? (sl ? 32 : 16) : n;
  endfunction

  // Whole frame as a bit string, first bit in [63]
  function automatic logic [63:0] exp_stream(input logic [70:0] v);
    int ch, n;
    logic [63:0] m, l, r, f;
    ch = v[68] ? 32 : 16;
    n  = nbits(v[67:66], v[68]);
    m  = (64'd1 << n) - 64'd1;
    l  = {32'd0, v[63:32]} & m;
    r  = {32'd0, v[31:0]} & m;
    case (v[70:69])
      2'd2:    f = (l << ch) | r;
      2'd3:    f = ((l << n) | r) << (2 * ch - 2 * n);
      default: f = (((l << (ch - n)) << ch)) | (r << (ch - n));
    endcase
    return f << (64 - 2 * ch);
  endfunction

  function automatic logic exp_sel(input logic [1:0] fmt, input int ch, input int q);
    if (fmt == 2'd3) return q == 2 * ch - 1;
    if (fmt == 2'd0) return ((q + 1) % (2 * ch)) >= ch;
    return q >= ch;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    int guard = 0;
    while (!tx_ready && guard < 2000) begin @(negedge clk); guard++; end
    tx_left = l; tx_right = r; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int base);
    int guard = 0;
    while (rx_cnt <= base && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state and idle levels
    check(!sck && !ws && !sd_out, "R1 idle pins after reset", {sck, ws, sd_out}, 0);
    check(tx_ready && !rx_valid && !tx_underrun && !rx_overrun, "R1 R13 reset flags",
          {tx_ready, rx_valid, tx_underrun, rx_overrun}, 4'b1000);

    // Table walk: R3..R9 serial layout, R10 loopback, R11 underrun, R2 bit period
    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      logic [63:0] st, msk;
      int ch, fl, base, rxb, bad_sd, bad_ws, n;
      v = VEC[i];
      fmt_sel = v[70:69]; slot_long = v[68]; smp_len = v[67:66];
      clk_inv = v[65]; ws_inv = v[64];
      do_reset();
      check(sck == clk_inv && ws == ws_inv, "R1 R9 idle levels with inversion", {sck, ws}, {clk_inv, ws_inv});
      ch = slot_long ? 32 : 16; fl = 2 * ch;
      n = nbits(smp_len, slot_long);
      msk = (64'd1 << n) - 64'd1;
      st = exp_stream(v);
      push(v[63:32], v[31:0]);
      base = rise_cnt; rxb = rx_cnt;
      enable = 1'b1;
      wait_rx(rxb);
      check(!tx_underrun, "R11 no underrun with data held", tx_underrun, 0);
      bad_sd = 0; bad_ws = 0;
      for (int q = 0; q < fl; q++) begin
        if (cap_sd[(base + q) % 512] !== st[63 - q]) bad_sd++;
        if (cap_ws[(base + q) % 512] !== exp_sel(fmt_sel, ch, q)) bad_ws++;
      end
      case (fmt_sel)
        2'd0: check(bad_sd == 0 && bad_ws == 0, "R3 R7 R8 classic layout", {bad_sd, bad_ws}, 0);
        2'd1: check(bad_sd == 0 && bad_ws == 0, "R4 R7 R8 MSB-aligned layout", {bad_sd, bad_ws}, 0);
        2'd2: check(bad_sd == 0 && bad_ws == 0, "R5 R7 R8 LSB-aligned padding", {bad_sd, bad_ws}, 0);
        default: check(bad_sd == 0 && bad_ws == 0, "R6 R7 R8 pulse-sync packing", {bad_sd, bad_ws}, 0);
      endcase
      check(cap_t[(base + fl - 1) % 512] - cap_t[base % 512] == (fl - 1) * 4, "R2 bit period of two strobes",
            cap_t[(base + fl - 1) % 512] - cap_t[base % 512], (fl - 1) * 4);
      check({got_l, got_r} == {v[63:32] & msk[31:0], v[31:0] & msk[31:0]}, "R10 R8 loopback pair",
            {got_l, got_r}, {v[63:32] & msk[31:0], v[31:0] & msk[31:0]});
      repeat (8) @(negedge clk);
      check(tx_underrun, "R11 underrun on empty frame start", tx_underrun, 1);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      check(sck == clk_inv && ws == ws_inv && !sd_out, "R1 idle after stop", {sck, ws, sd_out}, {clk_inv, ws_inv, 1'b0});
    end

    // R12 / R13: blocked offer, then unread pair across two frames
    fmt_sel = 2'd1; slot_long = 1'b0; smp_len = 2'd0; clk_inv = 1'b0; ws_inv = 1'b0;
    do_reset();
    rx_ready = 1'b0;
    push(32'h0000_1111, 32'h0000_2222);
    check(!tx_ready, "R13 ready low when holding full", tx_ready, 0);
    tx_left = 32'h0000_3333; tx_right = 32'h0000_4444; tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    enable = 1'b1;
    for (int g = 0; g < 2000 && !rx_valid; g++) @(negedge clk);
    check({rx_left, rx_right} == {32'h1111, 32'h2222}, "R13 blocked offer not taken",
          {rx_left, rx_right}, {32'h1111, 32'h2222});
    check(!rx_overrun, "R12 no overrun on first pair", rx_overrun, 0);
    repeat (32 * 4 + 16) @(negedge clk);
    check(rx_overrun, "R12 overrun on unread pair", rx_overrun, 1);
    check(rx_valid && rx_left == 32'h1111, "R12 unread pair kept", rx_left, 32'h1111);
    rx_ready = 1'b1;
    @(negedge clk);
    check(!rx_valid && rx_overrun, "R10 R12 pair taken, flag sticky", {rx_valid, rx_overrun}, 2'b01);

    // R1: stop in mid-frame with inverted clock
    clk_inv = 1'b1;
    do_reset();
    enable = 1'b1;
    repeat (37) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(sck && !ws && !sd_out, "R1 R9 mid-frame stop idles", {sck, ws, sd_out}, 3'b100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule